// File: doc/BRIEF.md
# Dual Compare-Match Timer

This block holds two independent 8-bit up-counters. Each counter has its own compare register and its own clock-source selector. A running counter advances by one on every tick of its selected source. When a tick arrives while the count equals the compare value, the counter returns to 00h on that tick and a sticky interrupt flag is raised. The counter therefore cycles through compare+1 states per period.

Timer A takes its ticks from a shared free-running prescaler that divides the system clock by 2, 4, 8, 32, 128, 512 or 2048. It can also take them from rising edges of an external event pin, which is first passed through a two-flop synchronizer. Timer B takes its ticks from the same prescaler, at ÷1, ÷2 or ÷8. Software reaches everything through a small synchronous register bus. Each timer's count and compare registers share one address: a read returns the live count and a write loads the compare value.

Register map (3-bit address, 8-bit data). Unused addresses and unused bits read 0.
- 0: control A, with bit 0 `run`, bit 1 `keep` and bits 4:2 `srcA`.
- 1: count A (read) / compare A (write).
- 2: control B, with bit 0 `run`, bit 1 `keep` and bits 3:2 `srcB`.
- 3: count B (read) / compare B (write).
- 4: flags, with bit 0 for timer A and bit 1 for timer B.

Top module: `tmr_pair`

## Requirements
- R1: After reset, both control registers read 00h, both counts read 00h, both flags are 0 and neither counter moves.
- R2: On each tick of its source, a running counter whose value differs from its compare value increments by one. If the value equals the compare value, the counter becomes 00h on that tick.
- R3: The tick that takes a counter from its compare value to 00h sets that timer's flag. The flag stays set until it is cleared, and it is set by nothing else.
- R4: A bus read of address 1 or 3 returns the live count. A bus write to either address loads the compare register and leaves the count unchanged.
- R5: Timer A `srcA` codes 000, 001, 010, 011, 100, 101 and 110 give one tick every 2, 4, 8, 32, 128, 512 and 2048 clock cycles.
- R6: With `srcA` = 111, timer A counts once per rising edge of `evtPin`, after a two-flop synchronizer. Edges that arrive while the timer is stopped are not counted.
- R7: Timer B `srcB` codes 00, 01 and 10 give one tick every 1, 2 and 8 clock cycles. Code 11 gives no ticks, so the counter holds its value.
- R8: Writing a control register with `run`=1 and `keep`=0 clears the count to 00h and starts the timer. Writing `run`=0 stops the timer, and the count holds.
- R9: Writing a control register with `run`=1 and `keep`=1 resumes counting from the held value without clearing it.
- R10: Writing 0 to a bit of the flag register clears that flag, and writing 1 has no effect. A high `irqAck` bit also clears the matching flag. A match in the same cycle as a clear leaves the flag set.
- R11: Control A reads back its bits 4:0 and control B reads back its bits 3:0. All higher bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe for the register bus |
| busAddr | input | 3 | Register address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for `busAddr` |
| evtPin | input | 1 | External event input, asynchronous |
| irqAck | input | 2 | Flag acknowledge, bit 0 for timer A and bit 1 for timer B |
| irqFlag | output | 2 | Latched match flags, bit 0 for timer A and bit 1 for timer B |

## Verification
The hardest situation to reach is an acknowledge that lands in exactly the cycle where a match sets the flag. The bench reaches it by starting timer B at ÷1 with a small compare value, so the match edge sits a known number of cycles after the start write. It raises `irqAck` for that single edge only. The prescaler is free-running, so its phase at start is unknown. The divider checks sidestep this by choosing a run window that is an exact multiple of the divisor, which makes the tick count independent of phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_TMR = 2;
  localparam int DATA_W  = 8;
  localparam int CNT_W   = 8;
  localparam int ADDR_W  = 3;
  localparam int NUM_TAP = 8;
  // log2 of every divisor offered by the prescaler
  localparam int TAP_LOG [NUM_TAP] = '{0, 1, 2, 3, 5, 7, 9, 11};
  localparam int PRE_W   = TAP_LOG[NUM_TAP-1];

  localparam logic [ADDR_W-1:0] ADDR_CTRL_A = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_DATA_A = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL_B = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_DATA_B = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_FLAG   = 3'd4;

  typedef struct packed {
    logic [NUM_TMR-1:0] tick;
    logic [NUM_TMR-1:0] clrCnt;
    logic [NUM_TMR-1:0] loadCmp;
    logic [NUM_TMR-1:0] clrFlag;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [4:0]          wrLow,
  input  logic                evtPin,
  input  logic [NUM_TMR-1:0]  irqAck,
  output tmrStrobe_t          strb,
  output logic [DATA_W-1:0]   ctrlRdA,
  output logic [DATA_W-1:0]   ctrlRdB
);
  logic runA, keepA, runB, keepB;
  logic [2:0] srcA;
  logic [1:0] srcB;
  logic [PRE_W-1:0] preCnt;
  logic [NUM_TAP-1:0] tap;
  logic [2:0] evtSync;
  logic evtRise, srcTickA, srcTickB;
  logic wrCtrlA, wrCtrlB, wrFlag;

  assign wrCtrlA = busWrEn && (busAddr == ADDR_CTRL_A);
  assign wrCtrlB = busWrEn && (busAddr == ADDR_CTRL_B);
  assign wrFlag  = busWrEn && (busAddr == ADDR_FLAG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {srcA, keepA, runA} <= '0;
      {srcB, keepB, runB} <= '0;
      preCnt  <= '0;
      evtSync <= '0;
    end else begin
      if (wrCtrlA) {srcA, keepA, runA} <= wrLow;
      if (wrCtrlB) {srcB, keepB, runB} <= wrLow[3:0];
      preCnt  <= preCnt + 1'b1;
      evtSync <= {evtSync[1:0], evtPin};
    end
  end

  // one pulse every 2**TAP_LOG[j] cycles
  for (genvar j = 0; j < NUM_TAP; j++) begin : g_tap
    if (TAP_LOG[j] == 0) begin : g_full
      assign tap[j] = 1'b1;
    end else begin : g_div
      assign tap[j] = &preCnt[TAP_LOG[j]-1:0];
    end
  end

  assign evtRise = evtSync[1] & ~evtSync[2];

  always_comb begin
    case (srcA)
      3'd0:    srcTickA = tap[1];
      3'd1:    srcTickA = tap[2];
      3'd2:    srcTickA = tap[3];
      3'd3:    srcTickA = tap[4];
      3'd4:    srcTickA = tap[5];
      3'd5:    srcTickA = tap[6];
      3'd6:    srcTickA = tap[7];
      default: srcTickA = evtRise;
    endcase
    case (srcB)
      2'd0:    srcTickB = tap[0];
      2'd1:    srcTickB = tap[1];
      2'd2:    srcTickB = tap[3];
      default: srcTickB = 1'b0;
    endcase
  end

  always_comb begin
    strb.tick       = {runB & srcTickB, runA & srcTickA};
    strb.clrCnt     = {wrCtrlB & wrLow[0] & ~wrLow[1], wrCtrlA & wrLow[0] & ~wrLow[1]};
    strb.loadCmp    = {busWrEn && (busAddr == ADDR_DATA_B), busWrEn && (busAddr == ADDR_DATA_A)};
    strb.clrFlag[0] = (wrFlag & ~wrLow[0]) | irqAck[0];
    strb.clrFlag[1] = (wrFlag & ~wrLow[1]) | irqAck[1];
  end

  assign ctrlRdA = DATA_W'({srcA, keepA, runA});
  assign ctrlRdB = DATA_W'({srcB, keepB, runB});
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  tmrStrobe_t                      strb,
  input  logic [DATA_W-1:0]               wrData,
  output logic [NUM_TMR-1:0][CNT_W-1:0]   cntVal,
  output logic [NUM_TMR-1:0][CNT_W-1:0]   cmpVal,
  output logic [NUM_TMR-1:0]              flagVal
);
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_ch
    logic atMatch;
    assign atMatch = strb.tick[i] && !strb.clrCnt[i] && (cntVal[i] == cmpVal[i]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntVal[i]  <= '0;
        cmpVal[i]  <= '1;
        flagVal[i] <= 1'b0;
      end else begin
        if (strb.loadCmp[i]) cmpVal[i] <= wrData[CNT_W-1:0];
        if (strb.clrCnt[i])  cntVal[i] <= '0;
        else if (strb.tick[i])
          cntVal[i] <= (cntVal[i] == cmpVal[i]) ? '0 : cntVal[i] + 1'b1;
        if (atMatch)              flagVal[i] <= 1'b1;
        else if (strb.clrFlag[i]) flagVal[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic                evtPin,
  input  logic [NUM_TMR-1:0]  irqAck,
  output logic [NUM_TMR-1:0]  irqFlag
);
  tmrStrobe_t strb;
  logic [NUM_TMR-1:0][CNT_W-1:0] cntVal;
  logic [NUM_TMR-1:0][CNT_W-1:0] cmpVal;
  logic [DATA_W-1:0] ctrlRdA, ctrlRdB;

  tmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .wrLow(busWrData[4:0]), .evtPin(evtPin), .irqAck(irqAck),
    .strb(strb), .ctrlRdA(ctrlRdA), .ctrlRdB(ctrlRdB)
  );

  tmr_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWrData),
    .cntVal(cntVal), .cmpVal(cmpVal), .flagVal(irqFlag)
  );

  always_comb begin
    case (busAddr)
      ADDR_CTRL_A: busRdData = ctrlRdA;
      ADDR_DATA_A: busRdData = DATA_W'(cntVal[0]);
      ADDR_CTRL_B: busRdData = ctrlRdB;
      ADDR_DATA_B: busRdData = DATA_W'(cntVal[1]);
      ADDR_FLAG:   busRdData = DATA_W'(irqFlag);
      default:     busRdData = '0;
    endcase
  end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
  import tmr_pkg::*;
(
  input logic                           clk,
  input logic                           rstN,
  input tmrStrobe_t                     strb,
  input logic [NUM_TMR-1:0][CNT_W-1:0]  cntVal,
  input logic [NUM_TMR-1:0][CNT_W-1:0]  cmpVal,
  input logic [NUM_TMR-1:0]             flagVal
);
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.tick[i] && !strb.clrCnt[i] && cntVal[i] == cmpVal[i]) |=> cntVal[i] == '0);
    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.tick[i] && !strb.clrCnt[i] && cntVal[i] != cmpVal[i])
        |=> cntVal[i] == CNT_W'($past(cntVal[i]) + 1'b1));
    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.tick[i] && !strb.clrCnt[i]) |=> $stable(cntVal[i]));
    // R8
    start_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.clrCnt[i] |=> cntVal[i] == '0);
    // R3
    match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.tick[i] && !strb.clrCnt[i] && cntVal[i] == cmpVal[i]) |=> flagVal[i]);
    // R3
    flag_only_on_match_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flagVal[i]) |-> $past(strb.tick[i] && !strb.clrCnt[i] && cntVal[i] == cmpVal[i]));
    // R10
    clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.clrFlag[i] && !(strb.tick[i] && !strb.clrCnt[i] && cntVal[i] == cmpVal[i]))
        |=> !flagVal[i]);
    // R4
    cmp_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strb.loadCmp[i] |=> $stable(cmpVal[i]));
  end
endmodule

bind tmr_pair tmr_pair_chk u_chk (
  .clk(clk), .rstN(rstN), .strb(strb),
  .cntVal(cntVal), .cmpVal(cmpVal), .flagVal(irqFlag)
);

// File: tb/tmr_pair_bench.sv
module tmr_pair_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic evtPin = 1'b0;
  logic [1:0] irqAck = '0;
  logic [1:0] irqFlag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] exp;
    bit         pins;
    string      tag;
  } item_t;
  item_t expQ[$];

  always #5 clk = ~clk;

  tmr_pair u_tmr_pair (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .evtPin(evtPin),
    .irqAck(irqAck), .irqFlag(irqFlag)
  );

  // monitor: compares queued expectations just after each falling edge
  initial forever begin
    item_t it;
    logic [7:0] act;
    @(negedge clk);
    #1;
    while (expQ.size() > 0) begin
      it = expQ.pop_front();
      act = it.pins ? {6'b0, irqFlag} : busRdData;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    busAddr = a;
    expQ.push_back('{exp: e, pins: 1'b0, tag: t});
  endtask

  task automatic pinChk(input logic [1:0] e, input string t);
    @(negedge clk);
    expQ.push_back('{exp: {6'b0, e}, pins: 1'b1, tag: t});
  endtask

  // the edges counted span exactly k+2 cycles
  task automatic runWin(input logic [2:0] a, input logic [7:0] v, input int k);
    wr(a, v);
    repeat (k) @(negedge clk);
    wr(a, v & 8'hFE);
  endtask

  task automatic pulses(input int n);
    for (int p = 0; p < n; p++) begin
      @(negedge clk); evtPin = 1'b1;
      repeat (3) @(negedge clk);
      evtPin = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int selCode [7] = '{0, 1, 2, 3, 4, 5, 6};
    int divs    [7] = '{2, 4, 8, 32, 128, 512, 2048};
    int mult    [7] = '{5, 4, 3, 3, 2, 1, 1};
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    peek(3'd0, 8'h00, "R1 ctrlA");
    peek(3'd1, 8'h00, "R1 countA");
    peek(3'd2, 8'h00, "R1 ctrlB");
    peek(3'd3, 8'h00, "R1 countB");
    peek(3'd4, 8'h00, "R1 flags");
    pinChk(2'b00, "R1 flag pins");

    // R2 R3 R8: timer B /1, compare 5, 7 ticks -> 1,2,3,4,5,0,1
    wr(3'd3, 8'd5);
    peek(3'd3, 8'h00, "R4 compare write keeps count");
    runWin(3'd2, 8'h01, 5);
    peek(3'd3, 8'h01, "R2 wrap count");
    peek(3'd4, 8'h02, "R3 flag latched");
    pinChk(2'b10, "R3 flag pin");

    // R10: write 0 clears, write 1 does nothing
    wr(3'd4, 8'h01);
    peek(3'd4, 8'h00, "R10 write-0 clears");

    // R10: ack in the very cycle of a match loses to the match
    wr(3'd3, 8'd3);
    wr(3'd2, 8'h01);
    repeat (3) @(negedge clk);
    irqAck = 2'b10;
    @(negedge clk);
    irqAck = 2'b00;
    wr(3'd2, 8'h00);
    pinChk(2'b10, "R10 match beats ack");
    @(negedge clk); irqAck = 2'b10;
    @(negedge clk); irqAck = 2'b00;
    pinChk(2'b00, "R10 ack clears");
    peek(3'd3, 8'h02, "R8 stopped count holds");

    // R9: resume without clearing, 3 ticks from 2
    wr(3'd3, 8'd9);
    runWin(3'd2, 8'h03, 1);
    peek(3'd3, 8'h05, "R9 keep resumes");
    wr(3'd3, 8'hFF);
    peek(3'd3, 8'h05, "R4 count survives compare write");

    // R7 timer B dividers
    runWin(3'd2, 8'h05, 6);
    peek(3'd3, 8'h04, "R7 div2");
    runWin(3'd2, 8'h09, 14);
    peek(3'd3, 8'h02, "R7 div8");
    runWin(3'd2, 8'h0F, 20);
    peek(3'd3, 8'h02, "R7 code 11 holds");

    // R5 timer A dividers
    wr(3'd1, 8'hFF);
    for (int s = 0; s < 7; s++) begin
      runWin(3'd0, 8'((selCode[s] << 2) | 1), divs[s] * mult[s] - 2);
      peek(3'd1, 8'(mult[s]), $sformatf("R5 div%0d", divs[s]));
    end

    // R6 event counting
    wr(3'd0, 8'h1D);
    peek(3'd0, 8'h1D, "R11 ctrlA readback");
    pulses(4);
    repeat (4) @(negedge clk);
    wr(3'd0, 8'h1C);
    peek(3'd1, 8'h04, "R6 four edges");
    pulses(3);
    repeat (4) @(negedge clk);
    wr(3'd0, 8'h1F);
    repeat (6) @(negedge clk);
    wr(3'd0, 8'h1E);
    peek(3'd1, 8'h04, "R6 edges ignored while stopped");
    wr(3'd0, 8'h1F);
    pulses(1);
    repeat (4) @(negedge clk);
    wr(3'd0, 8'h1E);
    peek(3'd1, 8'h05, "R6 counting resumes");

    // R3 R10 on timer A: compare 1, /2, 2 ticks -> 1,0
    wr(3'd1, 8'd1);
    runWin(3'd0, 8'h01, 2);
    peek(3'd4, 8'h01, "R3 timer A flag");
    wr(3'd4, 8'h02);
    peek(3'd4, 8'h00, "R10 bit0 cleared, bit1 write-1 inert");
    wr(3'd4, 8'h03);
    peek(3'd4, 8'h00, "R10 write-1 sets nothing");

    // R11 readback widths
    wr(3'd2, 8'hFE);
    peek(3'd2, 8'h0E, "R11 ctrlB readback");
    wr(3'd0, 8'hFE);
    peek(3'd0, 8'h1E, "R11 ctrlA upper bits");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule